// File: doc/BRIEF.md
# Int8 Tile Accumulator

The block runs the inner loop of an 8-bit integer matrix product C = A·B. C is a 16x16 tile of 32-bit accumulators held inside the block. A command starts a pass over the active rows of the tile. The block takes one row per clock. For that row it receives four A bytes and a 4x16 slice of B, and it forms sixteen lanes at once. Each lane multiplies four byte pairs and adds the four products and the old accumulator in a single five-input sum.

A command carries the following fields:
- an action: overwrite the tile with the product, add the product into it, or stream accumulator plus product out on a write port without changing the tile;
- a signedness flag, which applies to both operands;
- the active row count and the active column count, each 1 to 16;
- the number of live inner elements, 1 to 4. The remaining inner positions are treated as zero.

Software moves through the inner dimension four elements at a time. It issues one command per group of four: set for the first group, accumulate for the middle groups and emit for the last group. A combinational read port lets the surrounding logic inspect any stored row.

Top module: `imx_tile_acc`

## Requirements
- R1: Each lane computes acc + a0·b0 + a1·b1 + a2·b2 + a3·b3, where a_j is byte j of `a_i` (bits 8j+7:8j) and b_j is B[j][lane], taken from `b_i` bits (16j+lane)·8+7 down to (16j+lane)·8.
- R2: Row r of a command is consumed at the (r+1)-th rising edge after the accept edge. `row_o` shows the row being consumed while `busy_o` is high.
- R3: Op code 0 (set) stores the product alone, ignoring the previous accumulator.
- R4: Op code 1 (accumulate) adds the product to the stored accumulator.
- R5: Op code 2 (emit) leaves the stored tile unchanged. One cycle after each row edge, it presents `wr_valid_o`=1, `wr_row_o`=row and `wr_data_o` lane c (bits 32c+31:32c) = accumulator + product, with 0 in inactive lanes. At all other times `wr_valid_o` is 0.
- R6: When `cmd_signed_i`=1, operands are two's-complement bytes. When it is 0, operands are unsigned bytes.
- R7: All sums wrap modulo 2^32 with no saturation.
- R8: Inner positions j greater than `cmd_k_m1_i` contribute zero.
- R9: Only rows 0..`cmd_rows_m1_i` and columns 0..`cmd_cols_m1_i` are written. Every other accumulator keeps its value.
- R10: `busy_o` rises the cycle after a command is accepted and stays high for exactly rows cycles. A command offered while busy is ignored, and so is one with op code 3.
- R11: After reset, all accumulators read 0, and `busy_o` and `wr_valid_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command offered this cycle |
| cmd_op_i | input | 2 | 0 set, 1 accumulate, 2 emit, 3 ignored |
| cmd_signed_i | input | 1 | 1 signed operands, 0 unsigned |
| cmd_rows_m1_i | input | 4 | Active rows minus one |
| cmd_cols_m1_i | input | 4 | Active columns minus one |
| cmd_k_m1_i | input | 2 | Live inner elements minus one |
| a_i | input | 32 | Four A bytes for the current row |
| b_i | input | 512 | 4x16 B slice, inner-major |
| busy_o | output | 1 | Command in progress |
| row_o | output | 4 | Row consumed at the next edge |
| wr_valid_o | output | 1 | Emit result valid |
| wr_row_o | output | 4 | Row of emitted result |
| wr_data_o | output | 512 | Sixteen 32-bit emitted lanes |
| rd_row_i | input | 4 | Read port row select |
| rd_data_o | output | 512 | Stored row, sixteen 32-bit lanes |

## Verification
Suppose a lane sum, an extension or a write enable goes wrong. The error lands in the stored tile, and the read port shows it as soon as the command completes. In emit mode it also shows on `wr_data_o` one cycle after the faulty row edge. A wrong row counter or a wrong busy length shows up in the same cycle on `row_o` and `busy_o`. The model keeps a full copy of the tile, so a write into an inactive row or column is caught at the next full readback, even when it arrives commands later.

// File: rtl/imx_pkg.sv
package imx_pkg;
  typedef enum logic [1:0] {
    OP_SET  = 2'd0,
    OP_ACC  = 2'd1,
    OP_EMIT = 2'd2,
    OP_NONE = 2'd3
  } op_e;
endpackage

// File: rtl/imx_dot_lane.sv
module imx_dot_lane #(
  parameter int unsigned K  = 4,
  parameter int unsigned AW = 8,
  parameter int unsigned CW = 32
) (
  input  logic [K-1:0][AW-1:0] a_i,
  input  logic [K-1:0][AW-1:0] b_i,
  input  logic [K-1:0]         k_en_i,
  input  logic                 sgn_i,
  input  logic [CW-1:0]        acc_i,
  output logic [CW-1:0]        sum_o
);
  localparam int unsigned PW = 2*AW + 2;

  logic [K-1:0][CW-1:0] ext;

  for (genvar j = 0; j < K; j++) begin : g_prod
    logic signed [AW:0]   ax, bx;
    logic signed [PW-1:0] p;
    assign ax = {sgn_i & a_i[j][AW-1], a_i[j]};
    assign bx = {sgn_i & b_i[j][AW-1], b_i[j]};
    assign p  = ax * bx;
    assign ext[j] = k_en_i[j] ? {{(CW-PW){p[PW-1]}}, p} : '0;
  end

  // five-way add, wraps mod 2^CW
  always_comb begin
    sum_o = acc_i;
    for (int j = 0; j < K; j++) sum_o = sum_o + ext[j];
  end
endmodule

// File: rtl/imx_seq.sv
module imx_seq
  import imx_pkg::*;
#(
  parameter int unsigned N  = 16,
  parameter int unsigned K  = 4,
  localparam int unsigned RW = $clog2(N),
  localparam int unsigned KW = $clog2(K)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmd_valid_i,
  input  logic [1:0]    cmd_op_i,
  input  logic          cmd_signed_i,
  input  logic [RW-1:0] cmd_rows_m1_i,
  input  logic [RW-1:0] cmd_cols_m1_i,
  input  logic [KW-1:0] cmd_k_m1_i,
  output logic          busy_o,
  output logic [RW-1:0] row_o,
  output op_e           op_o,
  output logic          sgn_o,
  output logic [RW-1:0] cols_m1_o,
  output logic [KW-1:0] k_m1_o
);
  logic          busy_q;
  logic [RW-1:0] row_q, rows_q;
  logic          accept, last;

  assign accept = cmd_valid_i && !busy_q && (cmd_op_i != OP_NONE);
  assign last   = (row_q == rows_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q    <= 1'b0;
      row_q     <= '0;
      rows_q    <= '0;
      cols_m1_o <= '0;
      k_m1_o    <= '0;
      op_o      <= OP_SET;
      sgn_o     <= 1'b0;
    end else if (accept) begin
      busy_q    <= 1'b1;
      row_q     <= '0;
      rows_q    <= cmd_rows_m1_i;
      cols_m1_o <= cmd_cols_m1_i;
      k_m1_o    <= cmd_k_m1_i;
      op_o      <= op_e'(cmd_op_i);
      sgn_o     <= cmd_signed_i;
    end else if (busy_q) begin
      if (last) busy_q <= 1'b0;
      else      row_q  <= row_q + 1'b1;
    end
  end

  assign busy_o = busy_q;
  assign row_o  = row_q;

  AST_BUSY_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && !last |=> busy_q && (row_q == $past(row_q) + 1'b1)); // R10
  AST_BUSY_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && last |=> !busy_q); // R10
  AST_BAD_OP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q && cmd_op_i == OP_NONE |=> !busy_q); // R10
  AST_START_ROW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> row_q == '0); // R2
endmodule

// File: rtl/imx_acc_file.sv
module imx_acc_file #(
  parameter int unsigned N  = 16,
  parameter int unsigned CW = 32,
  localparam int unsigned RW = $clog2(N)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [RW-1:0]        wrow_i,
  input  logic [N-1:0]         col_en_i,
  input  logic [N-1:0][CW-1:0] wdata_i,
  output logic [N-1:0][CW-1:0] crow_o,
  input  logic [RW-1:0]        rd_row_i,
  output logic [N-1:0][CW-1:0] rd_data_o
);
  logic [N-1:0][N-1:0][CW-1:0] mem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_q <= '0;
    end else if (we_i) begin
      for (int c = 0; c < N; c++)
        if (col_en_i[c]) mem_q[wrow_i][c] <= wdata_i[c];
    end
  end

  assign crow_o    = mem_q[wrow_i];
  assign rd_data_o = mem_q[rd_row_i];

  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(mem_q)); // R5

  for (genvar c = 0; c < N; c++) begin : g_colchk
    AST_COL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      we_i && !col_en_i[c] |=> mem_q[$past(wrow_i)][c] == $past(mem_q[wrow_i][c])); // R9
  end
endmodule

// File: rtl/imx_tile_acc.sv
module imx_tile_acc
  import imx_pkg::*;
#(
  parameter int unsigned N  = 16,
  parameter int unsigned K  = 4,
  parameter int unsigned AW = 8,
  parameter int unsigned CW = 32,
  localparam int unsigned RW = $clog2(N),
  localparam int unsigned KW = $clog2(K)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cmd_valid_i,
  input  logic [1:0]          cmd_op_i,
  input  logic                cmd_signed_i,
  input  logic [RW-1:0]       cmd_rows_m1_i,
  input  logic [RW-1:0]       cmd_cols_m1_i,
  input  logic [KW-1:0]       cmd_k_m1_i,
  input  logic [K*AW-1:0]     a_i,
  input  logic [K*N*AW-1:0]   b_i,
  output logic                busy_o,
  output logic [RW-1:0]       row_o,
  output logic                wr_valid_o,
  output logic [RW-1:0]       wr_row_o,
  output logic [N*CW-1:0]     wr_data_o,
  input  logic [RW-1:0]       rd_row_i,
  output logic [N*CW-1:0]     rd_data_o
);
  op_e                  op;
  logic                 sgn, busy;
  logic [RW-1:0]        row, cols_m1;
  logic [KW-1:0]        k_m1;
  logic [K-1:0]         k_en;
  logic [N-1:0]         col_en;
  logic [N-1:0][CW-1:0] crow, sum, rd_row_data;
  logic [K-1:0][AW-1:0] a_vec;

  imx_seq #(.N(N), .K(K)) u_seq (
    .clk_i, .rst_ni, .cmd_valid_i, .cmd_op_i, .cmd_signed_i,
    .cmd_rows_m1_i, .cmd_cols_m1_i, .cmd_k_m1_i,
    .busy_o(busy), .row_o(row), .op_o(op), .sgn_o(sgn),
    .cols_m1_o(cols_m1), .k_m1_o(k_m1)
  );

  for (genvar j = 0; j < K; j++) begin : g_k
    assign k_en[j]  = (KW'(j) <= k_m1);
    assign a_vec[j] = a_i[j*AW +: AW];
  end

  for (genvar c = 0; c < N; c++) begin : g_lane
    logic [K-1:0][AW-1:0] b_col;
    for (genvar j = 0; j < K; j++) begin : g_b
      assign b_col[j] = b_i[(j*N+c)*AW +: AW];
    end
    assign col_en[c] = (RW'(c) <= cols_m1);
    imx_dot_lane #(.K(K), .AW(AW), .CW(CW)) u_lane (
      .a_i(a_vec), .b_i(b_col), .k_en_i(k_en), .sgn_i(sgn),
      .acc_i(op == OP_SET ? '0 : crow[c]), .sum_o(sum[c])
    );
  end

  imx_acc_file #(.N(N), .CW(CW)) u_acc (
    .clk_i, .rst_ni,
    .we_i(busy && op != OP_EMIT), .wrow_i(row), .col_en_i(col_en),
    .wdata_i(sum), .crow_o(crow), .rd_row_i, .rd_data_o(rd_row_data)
  );

  logic [N-1:0][CW-1:0] wr_data_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_valid_o <= 1'b0;
      wr_row_o   <= '0;
      wr_data_q  <= '0;
    end else begin
      wr_valid_o <= busy && op == OP_EMIT;
      if (busy && op == OP_EMIT) begin
        wr_row_o <= row;
        for (int c = 0; c < N; c++) wr_data_q[c] <= col_en[c] ? sum[c] : '0;
      end
    end
  end

  assign wr_data_o = wr_data_q;
  assign rd_data_o = rd_row_data;
  assign busy_o    = busy;
  assign row_o     = row;

  AST_EMIT_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy && op == OP_EMIT |=> wr_valid_o && wr_row_o == $past(row)); // R5
  AST_WR_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |=> !wr_valid_o); // R5
endmodule

// File: tb/imx_tile_acc_bench.sv
module imx_tile_acc_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cmd_valid = 1'b0;
  logic [1:0]   cmd_op = '0;
  logic         cmd_signed = 1'b0;
  logic [3:0]   cmd_rows = '0, cmd_cols = '0;
  logic [1:0]   cmd_k = '0;
  logic [31:0]  a = '0;
  logic [511:0] b = '0;
  logic         busy, wr_valid;
  logic [3:0]   row, wr_row;
  logic [511:0] wr_data, rd_data;
  logic [3:0]   rd_row = '0;

  int checks = 0, errors = 0;
  logic [31:0] model [16][16];

  always #10 clk = ~clk;

  imx_tile_acc u_imx_tile_acc (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op),
    .cmd_signed_i(cmd_signed), .cmd_rows_m1_i(cmd_rows), .cmd_cols_m1_i(cmd_cols),
    .cmd_k_m1_i(cmd_k), .a_i(a), .b_i(b), .busy_o(busy), .row_o(row),
    .wr_valid_o(wr_valid), .wr_row_o(wr_row), .wr_data_o(wr_data),
    .rd_row_i(rd_row), .rd_data_o(rd_data)
  );

  function automatic logic [31:0] ext8(logic [7:0] v, bit s);
    return s ? {{24{v[7]}}, v} : {24'h0, v};
  endfunction

  task automatic check(bit ok, string tag, logic [511:0] got, logic [511:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic readback(string tag);
    for (int r = 0; r < 16; r++) begin
      logic [511:0] e;
      for (int c = 0; c < 16; c++) e[c*32 +: 32] = model[r][c];
      rd_row = 4'(r);
      #1;
      check(rd_data === e, tag, rd_data, e);
    end
  endtask

  task automatic run_cmd(int op, bit s, int rm1, int cm1, int km1,
                         bit fill, logic [7:0] af, logic [7:0] bf, bit inject, string tag);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'(op); cmd_signed = s;
    cmd_rows = 4'(rm1); cmd_cols = 4'(cm1); cmd_k = 2'(km1);
    @(negedge clk);
    cmd_valid = 1'b0;
    if (op == 3) begin
      check(busy === 1'b0, "R10 op3 ignored", {511'b0, busy}, 512'b0);
      readback("R10 op3 tile");
      return;
    end
    check(busy === 1'b1, "R10 busy rise", {511'b0, busy}, 512'b1);
    for (int r = 0; r <= rm1; r++) begin
      logic [511:0] ew;
      logic [31:0]  e [16];
      for (int j = 0; j < 4; j++) a[j*8 +: 8] = fill ? af : 8'($urandom);
      for (int i = 0; i < 64; i++) b[i*8 +: 8] = fill ? bf : 8'($urandom);
      check(row === 4'(r) && busy === 1'b1, "R2 row index", {508'b0, row}, 512'(r));
      if (inject && r == 0) begin
        cmd_valid = 1'b1; cmd_op = 2'd0; cmd_rows = 4'd15; cmd_cols = 4'd15;
      end
      ew = '0;
      for (int c = 0; c < 16; c++) begin
        e[c] = (op == 0) ? 32'h0 : model[r][c];
        for (int j = 0; j <= km1; j++)
          e[c] = e[c] + ext8(a[j*8 +: 8], s) * ext8(b[(j*16+c)*8 +: 8], s);
        if (c <= cm1) ew[c*32 +: 32] = e[c];
      end
      @(negedge clk);
      cmd_valid = 1'b0;
      if (op == 2) begin
        check(wr_valid === 1'b1 && wr_row === 4'(r), {tag, " R5 emit tag"},
              {507'b0, wr_valid, wr_row}, {507'b0, 1'b1, 4'(r)});
        check(wr_data === ew, {tag, " R5 emit data"}, wr_data, ew);
      end else begin
        for (int c = 0; c <= cm1; c++) model[r][c] = e[c];
        check(wr_valid === 1'b0, "R5 no emit", {511'b0, wr_valid}, 512'b0);
      end
    end
    check(busy === 1'b0, "R10 busy length", {511'b0, busy}, 512'b0);
    readback(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int r = 0; r < 16; r++) for (int c = 0; c < 16; c++) model[r][c] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check(busy === 1'b0 && wr_valid === 1'b0, "R11 reset flags",
          {510'b0, busy, wr_valid}, 512'b0);
    readback("R11 reset tile");
    run_cmd(0, 1, 15, 15, 3, 0, 0, 0, 0, "R3 set full");
    run_cmd(1, 0, 15, 15, 3, 0, 0, 0, 0, "R4 accumulate");
    run_cmd(2, 1, 15, 15, 3, 0, 0, 0, 0, "R5 emit");
    run_cmd(0, 0, 0, 0, 0, 0, 0, 0, 0, "R9 1x1");
    run_cmd(0, 1, 2, 4, 1, 1, 8'hFF, 8'hFF, 0, "R8 k2 signed");
    run_cmd(1, 0, 6, 9, 2, 0, 0, 0, 0, "R9 partial");
    run_cmd(3, 0, 15, 15, 3, 0, 0, 0, 0, "R10 op3");
    run_cmd(1, 1, 5, 15, 3, 0, 0, 0, 1, "R10 inject");
    run_cmd(0, 1, 15, 15, 3, 1, 8'hFF, 8'h01, 0, "R7 negative");
    run_cmd(1, 0, 15, 15, 3, 1, 8'hFF, 8'h01, 0, "R7 wrap");
    run_cmd(2, 1, 3, 15, 3, 1, 8'h80, 8'h80, 0, "R6 signed ext");
    run_cmd(2, 0, 3, 15, 3, 1, 8'h80, 8'h80, 0, "R6 unsigned ext");
    for (int n = 0; n < 30; n++)
      run_cmd(int'($urandom % 3), 1'($urandom), int'($urandom % 16), int'($urandom % 16),
              int'($urandom % 4), 0, 0, 0, 1'($urandom), "R1 random");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule